// File: doc/BRIEF.md
# Address-Window Port I/O Request Router

This block is one hop on the path between a requester and a set of downstream ports. It takes port-I/O request messages from an upstream valid/ready channel. Each message carries a command, an address-space tag, a 16-bit port address, a size and a data byte. The block compares the message against a small set of programmable inclusive address windows and forwards it to the port whose window matches. A read opens a single outstanding transaction. The block remembers which port received the read, takes the reply from that port only, and sends the reply upstream. The reply carries the original request's space, address and size.

Requests that hit no window go to a programmable default port. This includes every request in memory space. When the default port is switched off, writes are consumed silently and reads are answered locally with an all-ones data byte. Windows and the default entry are loaded through a one-cycle configuration write port.

Top module: `io_route_node`

## Requirements
- R1: After a synchronous active-low reset, every window and the default entry are disabled, no downstream request or upstream reply is valid, no downstream reply is accepted, and the upstream request channel is ready.
- R2: A WRITE (code 0) or READ (code 1) in I/O space (space bit 0) whose address satisfies base <= address <= limit of an enabled window is presented on exactly that window's port. The command, space, address, size and data are unchanged.
- R3: When several enabled windows contain the address, window index i drives port i, and the lowest-numbered matching window wins.
- R4: A WRITE or READ that matches no enabled window is sent to the default port when the default entry is enabled. Every memory-space request (space bit 1) falls in this group.
- R5: With no route, a WRITE is consumed and dropped. A READ with no route is answered upstream with data 0xFF. A request whose command is neither WRITE nor READ is consumed without any downstream request or reply.
- R6: A read reply leaves upstream with command READ_REPLY (code 2), the space, address and size of the read, and the data byte returned by the port.
- R7: From the cycle a READ is accepted until its upstream reply is accepted, the upstream request ready stays low.
- R8: While a read is outstanding, only the port that received it sees its reply ready asserted. A reply message from that port whose command is not READ_REPLY is consumed and discarded, and the block keeps waiting.
- R9: A WRITE that is forwarded or dropped produces no upstream reply.
- R10: A transfer happens only when valid and ready are both high. The upstream request ready follows the chosen port's ready. The upstream reply holds valid and all its fields until it is accepted.
- R11: A configuration write with selector below the port count loads that window's base, limit and enable. Selector equal to the port count loads the default port number and its enable. Both take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Window index, or port count for the default entry |
| cfg_base | input | 16 | Window base address (inclusive) |
| cfg_limit | input | 16 | Window limit address (inclusive) |
| cfg_port | input | 2 | Default port number |
| cfg_en | input | 1 | Enable for the selected entry |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_cmd | input | 2 | Request command |
| up_req_space | input | 1 | Request address space |
| up_req_addr | input | 16 | Request port address |
| up_req_size | input | 2 | Request size in bytes |
| up_req_data | input | 8 | Write data |
| dn_req_valid | output | 4 | Per-port request valid |
| dn_req_ready | input | 4 | Per-port request ready |
| dn_req_cmd | output | 2 | Forwarded command |
| dn_req_space | output | 1 | Forwarded space |
| dn_req_addr | output | 16 | Forwarded address |
| dn_req_size | output | 2 | Forwarded size |
| dn_req_data | output | 8 | Forwarded data |
| dn_rpl_valid | input | 4 | Per-port reply valid |
| dn_rpl_ready | output | 4 | Per-port reply ready |
| dn_rpl_cmd | input | 8 | Per-port reply command, 2 bits per port |
| dn_rpl_data | input | 32 | Per-port reply data, 8 bits per port |
| up_rpl_valid | output | 1 | Upstream reply valid |
| up_rpl_ready | input | 1 | Upstream reply ready |
| up_rpl_cmd | output | 2 | Reply command |
| up_rpl_space | output | 1 | Reply space |
| up_rpl_addr | output | 16 | Reply address |
| up_rpl_size | output | 2 | Reply size |
| up_rpl_data | output | 8 | Reply data |

## Verification
A corrupted window register or a broken priority choice shows in the same cycle as a request. The bench sees a wrong bit set in the downstream valid vector while the request is still presented. A wrong outstanding-read state shows on the next edge. It can appear as upstream ready reopening early, a reply ready raised on the wrong port, or an upstream reply whose address or data differ from the read that caused it. The bench compares each of these against a model of the windows, the default entry and the read-to-reply sequence. It does so for directed boundary addresses and for a seeded random mix of windows and requests.

// File: rtl/io_route_pkg.sv
package io_route_pkg;
   typedef enum logic [1:0] {
      CMD_WR  = 2'd0,
      CMD_RD  = 2'd1,
      CMD_RPL = 2'd2
   } cmd_e;

   localparam logic SP_IO  = 1'b0;
   localparam logic SP_MEM = 1'b1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RPL  = 2'd2
   } rt_state_e;

   localparam logic [7:0] MISS_DATA = 8'hFF;
endpackage

// File: rtl/io_route_win.sv
module io_route_win
   import io_route_pkg::*;
#(
   parameter int NWIN = 4,
   parameter int AW   = 16,
   parameter int SW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [SW-1:0]   cfg_sel,
   input  logic [AW-1:0]   cfg_base,
   input  logic [AW-1:0]   cfg_limit,
   input  logic            cfg_en,
   input  logic            req_space,
   input  logic [AW-1:0]   req_addr,
   output logic [NWIN-1:0] hit
);
   if (NWIN < 1) begin : g_bad_nwin
      $error("io_route_win: NWIN must be at least 1");
   end

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      logic [AW-1:0] base_q;
      logic [AW-1:0] lim_q;
      logic          en_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= '0;
            lim_q  <= '0;
            en_q   <= 1'b0;
         end else if (cfg_we && cfg_sel == SW'(g)) begin
            base_q <= cfg_base;
            lim_q  <= cfg_limit;
            en_q   <= cfg_en;
         end
      end

      assign hit[g] = en_q && (req_space == SP_IO) &&
                      (req_addr >= base_q) && (req_addr <= lim_q);
   end
endmodule

// File: rtl/io_route_pick.sv
module io_route_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  hit,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit[i]) idx = IW'(i);
      end
   end

   assign any = |hit;
endmodule

// File: rtl/io_route_node.sv
module io_route_node
   import io_route_pkg::*;
#(
   parameter int NPORT = 4,
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int ZW    = 2,
   parameter int IW    = (NPORT > 1) ? $clog2(NPORT) : 1,
   parameter int SW    = $clog2(NPORT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [SW-1:0]       cfg_sel,
   input  logic [AW-1:0]       cfg_base,
   input  logic [AW-1:0]       cfg_limit,
   input  logic [IW-1:0]       cfg_port,
   input  logic                cfg_en,
   input  logic                up_req_valid,
   output logic                up_req_ready,
   input  logic [1:0]          up_req_cmd,
   input  logic                up_req_space,
   input  logic [AW-1:0]       up_req_addr,
   input  logic [ZW-1:0]       up_req_size,
   input  logic [DW-1:0]       up_req_data,
   output logic [NPORT-1:0]    dn_req_valid,
   input  logic [NPORT-1:0]    dn_req_ready,
   output logic [1:0]          dn_req_cmd,
   output logic                dn_req_space,
   output logic [AW-1:0]       dn_req_addr,
   output logic [ZW-1:0]       dn_req_size,
   output logic [DW-1:0]       dn_req_data,
   input  logic [NPORT-1:0]    dn_rpl_valid,
   output logic [NPORT-1:0]    dn_rpl_ready,
   input  logic [2*NPORT-1:0]  dn_rpl_cmd,
   input  logic [DW*NPORT-1:0] dn_rpl_data,
   output logic                up_rpl_valid,
   input  logic                up_rpl_ready,
   output logic [1:0]          up_rpl_cmd,
   output logic                up_rpl_space,
   output logic [AW-1:0]       up_rpl_addr,
   output logic [ZW-1:0]       up_rpl_size,
   output logic [DW-1:0]       up_rpl_data
);
   if (NPORT < 1 || NPORT > 4) begin : g_bad_nport
      $error("io_route_node: NPORT must be 1 to 4");
   end
   if (DW < 8) begin : g_bad_dw
      $error("io_route_node: DW must hold the miss byte");
   end

   logic [NPORT-1:0] hit;
   logic             hit_any;
   logic [IW-1:0]    hit_idx;

   io_route_win #(.NWIN(NPORT), .AW(AW), .SW(SW)) u_win (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_en(cfg_en),
      .req_space(up_req_space), .req_addr(up_req_addr), .hit(hit)
   );

   io_route_pick #(.N(NPORT), .IW(IW)) u_pick (
      .hit(hit), .any(hit_any), .idx(hit_idx)
   );

   // default entry
   logic [IW-1:0] dflt_port_q;
   logic          dflt_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dflt_port_q <= '0;
         dflt_en_q   <= 1'b0;
      end else if (cfg_we && cfg_sel == SW'(NPORT)) begin
         dflt_port_q <= cfg_port;
         dflt_en_q   <= cfg_en && (int'(cfg_port) < NPORT);
      end
   end

   // route decision
   rt_state_e     st_q;
   logic [IW-1:0] tgt_q;
   logic          cap_space_q;
   logic [AW-1:0] cap_addr_q;
   logic [ZW-1:0] cap_size_q;
   logic [DW-1:0] cap_data_q;

   logic          is_rd, is_wr, rt_ok, fwd, accept;
   logic [IW-1:0] rt_port;

   assign is_rd   = (up_req_cmd == CMD_RD);
   assign is_wr   = (up_req_cmd == CMD_WR);
   assign rt_ok   = hit_any || dflt_en_q;
   assign rt_port = hit_any ? hit_idx : dflt_port_q;
   assign fwd     = (is_rd || is_wr) && rt_ok;

   always_comb begin
      dn_req_valid = '0;
      if (up_req_valid && st_q == ST_IDLE && fwd) dn_req_valid[rt_port] = 1'b1;
   end

   assign up_req_ready = (st_q == ST_IDLE) && (fwd ? dn_req_ready[rt_port] : 1'b1);
   assign accept       = up_req_valid && up_req_ready;

   assign dn_req_cmd   = up_req_cmd;
   assign dn_req_space = up_req_space;
   assign dn_req_addr  = up_req_addr;
   assign dn_req_size  = up_req_size;
   assign dn_req_data  = up_req_data;

   // outstanding read tracking
   logic          tgt_valid;
   logic [1:0]    tgt_cmd;
   logic [DW-1:0] tgt_data;

   assign tgt_valid = dn_rpl_valid[tgt_q];
   assign tgt_cmd   = dn_rpl_cmd[tgt_q*2 +: 2];
   assign tgt_data  = dn_rpl_data[tgt_q*DW +: DW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         tgt_q       <= '0;
         cap_space_q <= SP_IO;
         cap_addr_q  <= '0;
         cap_size_q  <= '0;
         cap_data_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (accept && is_rd) begin
                  cap_space_q <= up_req_space;
                  cap_addr_q  <= up_req_addr;
                  cap_size_q  <= up_req_size;
                  if (fwd) begin
                     tgt_q <= rt_port;
                     st_q  <= ST_WAIT;
                  end else begin
                     cap_data_q <= DW'(MISS_DATA);
                     st_q       <= ST_RPL;
                  end
               end
            end
            ST_WAIT: begin
               if (tgt_valid && tgt_cmd == CMD_RPL) begin
                  cap_data_q <= tgt_data;
                  st_q       <= ST_RPL;
               end
            end
            ST_RPL: begin
               if (up_rpl_ready) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      dn_rpl_ready = '0;
      if (st_q == ST_WAIT) dn_rpl_ready[tgt_q] = 1'b1;
   end

   assign up_rpl_valid = (st_q == ST_RPL);
   assign up_rpl_cmd   = CMD_RPL;
   assign up_rpl_space = cap_space_q;
   assign up_rpl_addr  = cap_addr_q;
   assign up_rpl_size  = cap_size_q;
   assign up_rpl_data  = cap_data_q;

   // checks
   p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_req_valid));

   p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_rpl_valid || dn_rpl_ready != '0) |-> !up_req_ready);

   p_rpl_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_rpl_ready));

   p_write_posted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_wr) |=> !up_rpl_valid);

   p_miss_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_rd && !fwd) |=> (up_rpl_valid && up_rpl_data == DW'(MISS_DATA)));

   p_hold_rpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_rpl_valid && !up_rpl_ready) |=>
         (up_rpl_valid && $stable(up_rpl_data) && $stable(up_rpl_addr) &&
          $stable(up_rpl_space) && $stable(up_rpl_size)));

   p_read_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_rd) |=> !up_req_ready);
endmodule

// File: tb/io_route_node_test.sv
`timescale 1ns/1ps
module io_route_node_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0;
   logic [2:0]  cfg_sel = 0;
   logic [15:0] cfg_base = 0, cfg_limit = 0;
   logic [1:0]  cfg_port = 0;
   logic        cfg_en = 0;
   logic        up_req_valid = 0;
   logic        up_req_ready;
   logic [1:0]  up_req_cmd = 0;
   logic        up_req_space = 0;
   logic [15:0] up_req_addr = 0;
   logic [1:0]  up_req_size = 1;
   logic [7:0]  up_req_data = 0;
   logic [3:0]  dn_req_valid;
   logic [3:0]  dn_req_ready = 4'hF;
   logic [1:0]  dn_req_cmd;
   logic        dn_req_space;
   logic [15:0] dn_req_addr;
   logic [1:0]  dn_req_size;
   logic [7:0]  dn_req_data;
   logic [3:0]  dn_rpl_valid = 0;
   logic [3:0]  dn_rpl_ready;
   logic [7:0]  dn_rpl_cmd = 0;
   logic [31:0] dn_rpl_data = 0;
   logic        up_rpl_valid;
   logic        up_rpl_ready = 0;
   logic [1:0]  up_rpl_cmd;
   logic        up_rpl_space;
   logic [15:0] up_rpl_addr;
   logic [1:0]  up_rpl_size;
   logic [7:0]  up_rpl_data;

   always #2.5 clk = ~clk;

   io_route_node uut (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [15:0] m_base [4];
   logic [15:0] m_lim  [4];
   logic        m_en   [4];
   logic [1:0]  m_dport = 0;
   logic        m_den = 0;

   task automatic chk(input string r, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic int exp_port(input logic sp, input logic [15:0] a);
      for (int i = 0; i < 4; i++)
         if (m_en[i] && sp == 1'b0 && a >= m_base[i] && a <= m_lim[i]) return i;
      if (m_den) return int'(m_dport);
      return -1;
   endfunction

   task automatic cfg(input int sel, input logic [15:0] b, input logic [15:0] l,
                      input logic [1:0] p, input logic en);
      @(negedge clk);
      cfg_we = 1; cfg_sel = 3'(sel); cfg_base = b; cfg_limit = l; cfg_port = p; cfg_en = en;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0;
      if (sel < 4) begin m_base[sel] = b; m_lim[sel] = l; m_en[sel] = en; end
      else begin m_dport = p; m_den = en; end
   endtask

   task automatic txn(input logic [1:0] c, input logic sp, input logic [15:0] a, input logic stall);
      int e;
      logic [3:0] ev;
      logic [7:0] d, expd;
      @(negedge clk);
      up_req_valid = 1; up_req_cmd = c; up_req_space = sp; up_req_addr = a;
      up_req_size = 2'(1); up_req_data = 8'($urandom);
      #1;
      e  = exp_port(sp, a);
      ev = (e >= 0 && c <= 2'd1) ? 4'(1 << e) : 4'h0;
      chk("R2/R3/R4 route vector", dn_req_valid, ev);
      if (ev != 0) begin
         chk("R2 forwarded addr", dn_req_addr, a);
         chk("R2 forwarded cmd", dn_req_cmd, c);
      end
      chk("R10 request ready", up_req_ready, 1);
      @(posedge clk);
      @(negedge clk);
      up_req_valid = 0;
      if (c == 2'd1) begin
         #1;
         chk("R7 stall after read", up_req_ready, 0);
         if (ev != 0) begin
            chk("R8 reply ready target", dn_rpl_ready, ev);
            d = 8'($urandom);
            dn_rpl_data = $urandom;
            dn_rpl_data[e*8 +: 8] = d;
            dn_rpl_cmd = 8'hAA;
            dn_rpl_valid = 4'hF;
            @(posedge clk);
            @(negedge clk);
            dn_rpl_valid = 0;
            expd = d;
         end else expd = 8'hFF;
         #1;
         chk("R6 reply valid", up_rpl_valid, 1);
         chk("R6 reply cmd", up_rpl_cmd, 2);
         chk("R6 reply addr", up_rpl_addr, a);
         chk("R6 reply space", up_rpl_space, sp);
         chk("R6 reply size", up_rpl_size, 1);
         chk("R5/R6 reply data", up_rpl_data, expd);
         if (stall) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            chk("R10 reply held", up_rpl_valid, 1);
            chk("R10 reply data held", up_rpl_data, expd);
            chk("R7 still stalled", up_req_ready, 0);
         end
         @(negedge clk);
         up_rpl_ready = 1;
         @(posedge clk);
         @(negedge clk);
         up_rpl_ready = 0;
         #1;
         chk("R7 reopen", up_req_ready, 1);
         chk("R7 reply gone", up_rpl_valid, 0);
      end else begin
         #1;
         chk("R9/R5 no reply", up_rpl_valid, 0);
         chk("R9 still ready", up_req_ready, 1);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_lim[i] = 0; m_en[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 dn valid idle", dn_req_valid, 0);
      chk("R1 reply idle", up_rpl_valid, 0);
      chk("R1 ready", up_req_ready, 1);
      chk("R1 no reply ready", dn_rpl_ready, 0);
      txn(2'd1, 1'b0, 16'h1234, 1'b0);   // R1 R5 read with nothing enabled
      txn(2'd0, 1'b0, 16'h0042, 1'b0);   // R5 write dropped

      // R11 R3 overlapping windows
      cfg(0, 16'h0000, 16'h2000, 0, 1);
      cfg(1, 16'h1234, 16'h1235, 0, 1);
      cfg(2, 16'h8000, 16'h80FF, 0, 1);
      txn(2'd1, 1'b0, 16'h1234, 1'b1);   // R3 lowest wins
      txn(2'd0, 1'b0, 16'h2000, 1'b0);   // R2 limit inclusive
      txn(2'd0, 1'b0, 16'h7FFF, 1'b0);
      txn(2'd0, 1'b0, 16'h8000, 1'b0);
      txn(2'd1, 1'b0, 16'h80FF, 1'b0);
      txn(2'd0, 1'b0, 16'h8100, 1'b0);
      cfg(0, 16'h0000, 16'h2000, 0, 0);  // R11 disable
      txn(2'd1, 1'b0, 16'h1235, 1'b0);
      txn(2'd1, 1'b0, 16'h1236, 1'b0);

      // R4 default port
      cfg(4, 16'h0, 16'h0, 2'd3, 1);
      txn(2'd1, 1'b1, 16'h1234, 1'b0);   // memory space
      txn(2'd0, 1'b0, 16'h5555, 1'b0);

      // R5 illegal upstream command consumed
      txn(2'd2, 1'b0, 16'h1234, 1'b0);
      txn(2'd3, 1'b1, 16'h9999, 1'b0);

      // R10 backpressure on the chosen port
      @(negedge clk);
      dn_req_ready = 4'b0111;
      up_req_valid = 1; up_req_cmd = 0; up_req_space = 1; up_req_addr = 16'h0777;
      #1;
      chk("R10 valid under backpressure", dn_req_valid, 4'b1000);
      chk("R10 ready follows port", up_req_ready, 0);
      @(negedge clk);
      #1;
      chk("R10 still presented", dn_req_valid, 4'b1000);
      dn_req_ready = 4'hF;
      #0.5;
      chk("R10 ready released", up_req_ready, 1);
      @(posedge clk);
      @(negedge clk);
      up_req_valid = 0;

      // R8 reply only from target, wrong command discarded
      @(negedge clk);
      up_req_valid = 1; up_req_cmd = 1; up_req_space = 0; up_req_addr = 16'h1234;
      @(posedge clk);
      @(negedge clk);
      up_req_valid = 0;
      #1;
      chk("R8 ready only port1", dn_rpl_ready, 4'b0010);
      dn_rpl_valid = 4'b0110;
      dn_rpl_cmd   = 8'b00_10_00_00;    // port1 sends WRITE code, port2 READ_REPLY
      dn_rpl_data  = 32'h00_5A_33_00;
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R8 other port ignored", up_rpl_valid, 0);
      chk("R8 still waiting", dn_rpl_ready, 4'b0010);
      dn_rpl_cmd = 8'b00_10_10_00;
      @(posedge clk);
      @(negedge clk);
      dn_rpl_valid = 0;
      #1;
      chk("R8 reply from port1", up_rpl_valid, 1);
      chk("R8 data from port1", up_rpl_data, 8'h33);
      up_rpl_ready = 1;
      @(posedge clk);
      @(negedge clk);
      up_rpl_ready = 0;

      // random mix
      for (int it = 0; it < 250; it++) begin
         if (it % 25 == 0) begin
            for (int w = 0; w < 4; w++) begin
               logic [15:0] b;
               b = 16'($urandom);
               cfg(w, b, b + 16'($urandom_range(0, 2000)), 0, 1'($urandom));
            end
            cfg(4, 0, 0, 2'($urandom), 1'($urandom));
         end
         begin
            int w;
            logic [15:0] a;
            w = $urandom_range(0, 3);
            a = ($urandom_range(0, 3) == 0) ? 16'($urandom)
                : m_base[w] + 16'($urandom_range(0, 2000));
            txn(2'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0), a,
                1'($urandom_range(0, 3) == 0));
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule